// File: doc/BRIEF.md
# Predicated Half-Precision Vector Fused Multiply-Add

This block is one execution slot for a destructive, lane-predicated floating-point multiply-add. Each transaction brings a 32-bit instruction word, two multiplicand vectors, the accumulator vector (which is also the destination) and a predicate with one bit per byte of the vector. The block checks that the word is this operation and reads the element size from it. For 16-bit elements, every lane that the predicate enables gets the accumulator plus the product of the two multiplicands. The exact result is rounded once, to nearest with ties to even. Lanes that the predicate disables return their accumulator value bit for bit.

The vector is 128 bits wide by default, which gives eight half-precision lanes. The 32-bit and 64-bit element sizes decode correctly but have no datapath here. For them the block raises a flag and returns the accumulator unchanged. A word that fails the decode raises a separate flag and also returns the accumulator. Transactions enter and leave through valid/ready handshakes. When the output is not backpressured, the result appears a fixed three clock edges after acceptance. A stall on the output freezes the whole pipeline.

Top module: `pvfma_unit`

## Requirements
- R1: An instruction word matches only when bits [31:24] are 8'b01100101, bit 21 is 1, bits [15:13] are 3'b000 and the size field in bits [23:22] is not 2'b00. Any other word gives `dec_err`=1 and `unsupported`=0, and `result` equals `src_acc`.
- R2: A matching word with size 2'b10 or 2'b11 gives `unsupported`=1, `dec_err`=0 and `result` equal to `src_acc`. A matching word with size 2'b01 gives both flags 0. The two flags are never 1 together.
- R3: With size 2'b01, lane i occupies bits [16i+15:16i] of each vector and is active exactly when `pred[2i]` is 1. Odd predicate bits have no effect.
- R4: An active lane returns addend + (a × b) in IEEE half precision. The exact sum is rounded once to nearest, ties to even. Subnormal inputs and subnormal results are handled exactly.
- R5: An inactive lane returns its `src_acc` lane bit for bit. This includes the case where no lane is active.
- R6: An active lane returns 16'h7E00 if any input is a NaN, if infinity is multiplied by zero, or if an infinite product meets an infinite addend of the opposite sign.
- R7: An exact zero sum is -0 only when both the product and the addend are negative. Otherwise it is +0. An infinite operand gives an infinity of its sign. A rounded magnitude above the largest finite value gives an infinity with the sign of the exact sum.
- R8: When `out_ready` stays high, `out_valid` for an input accepted at one rising edge appears after the third rising edge that follows. `in_ready` is low only while `out_valid`=1 and `out_ready`=0.
- R9: While `out_valid`=1 and `out_ready`=0, the block holds `out_valid`, `result`, `dec_err` and `unsupported` stable.
- R10: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline valid bits |
| in_valid | input | 1 | Input transaction present |
| in_ready | output | 1 | Block can accept an input this cycle |
| insn | input | 32 | Instruction word to decode |
| src_a | input | VLEN | First multiplicand vector |
| src_b | input | VLEN | Second multiplicand vector |
| src_acc | input | VLEN | Addend vector, also the register being overwritten |
| pred | input | VLEN/8 | Predicate, one bit per vector byte |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| result | output | VLEN | New value of the addend/destination vector |
| dec_err | output | 1 | Instruction word is not this operation |
| unsupported | output | 1 | Valid encoding with an element size that has no datapath |

## Verification
Directed lanes target fused rounding and arithmetic corners. One lane has a product and addend that cancel to a tiny residue, which separates single rounding from double rounding. Other lanes cover halfway subnormal results, which test ties to even, along with overflow, both signed-zero cancellations and the three NaN-producing cases. Predicate patterns of all-off, odd-bits-only and sparse even bits check that lane activity comes only from the lowest byte bit of each lane. Malformed words and the wider size codes check the two flags and accumulator pass-through. Random operands drawn from full-range, near-equal-exponent and special-value pools run under random backpressure and are compared against an independent exact-integer model. These runs test cancellation, sign selection and the stall hold.

// File: rtl/pvfma_pkg.sv
`timescale 1ns/1ps
package pvfma_pkg;
   localparam int HALF_W   = 16;
   localparam int MANT_W   = 11;
   localparam int FRAC_W   = 10;
   // exact values are held as integers in units of 2^-50
   localparam int EXACT_W  = 84;
   localparam int POS_W    = 7;
   // bit position of the smallest subnormal (2^-24) in those units
   localparam int SUB_LSB  = 26;
   // shift that places an addend significand into the product scale
   localparam int ADD_OFS  = 25;
   localparam logic [HALF_W-1:0] QNAN    = 16'h7E00;
   localparam logic [14:0]       INF_MAG = 15'h7C00;

   typedef struct packed {
      logic               nan;
      logic               inf;
      logic               sgn;
      logic [EXACT_W-1:0] mag;
   } exact_t;

   function automatic logic [4:0] eff_exp(input logic [HALF_W-1:0] h);
      return (h[14:10] == 5'd0) ? 5'd1 : h[14:10];
   endfunction

   function automatic logic [MANT_W-1:0] signif(input logic [HALF_W-1:0] h);
      return {(h[14:10] != 5'd0), h[9:0]};
   endfunction

   function automatic logic is_nan(input logic [HALF_W-1:0] h);
      return (h[14:10] == 5'h1F) && (h[9:0] != 10'd0);
   endfunction

   function automatic logic is_inf(input logic [HALF_W-1:0] h);
      return (h[14:10] == 5'h1F) && (h[9:0] == 10'd0);
   endfunction

   function automatic logic is_zero(input logic [HALF_W-1:0] h);
      return h[14:0] == 15'd0;
   endfunction
endpackage

// File: rtl/pvfma_decode.sv
`timescale 1ns/1ps
module pvfma_decode (
   input  logic [31:0] insn,
   output logic        match,
   output logic        half_ok
);
   logic [1:0] size_f;
   logic       fields_unused;

   always_comb begin
      size_f  = insn[23:22];
      match   = (insn[31:24] == 8'b0110_0101) && insn[21] &&
                (insn[15:13] == 3'b000) && (size_f != 2'b00);
      half_ok = match && (size_f == 2'b01);
   end

   // register index fields select nothing inside this slot
   assign fields_unused = ^{insn[20:16], insn[12:0]};
endmodule

// File: rtl/pvfma_exact.sv
`timescale 1ns/1ps
module pvfma_exact
   import pvfma_pkg::*;
(
   input  logic [HALF_W-1:0] mul_x,
   input  logic [HALF_W-1:0] mul_y,
   input  logic [HALF_W-1:0] addend,
   output exact_t            ex
);
   logic [2*MANT_W-1:0] prod;
   logic [EXACT_W-1:0]  p_mag;
   logic [EXACT_W-1:0]  c_mag;
   logic                ps;
   logic                cs;
   logic                p_inf;
   logic                c_inf;
   logic                bad_mul;

   always_comb begin
      ps    = mul_x[15] ^ mul_y[15];
      cs    = addend[15];
      prod  = (2*MANT_W)'(signif(mul_x)) * (2*MANT_W)'(signif(mul_y));
      p_mag = EXACT_W'(prod) << (6'(eff_exp(mul_x)) + 6'(eff_exp(mul_y)));
      c_mag = EXACT_W'(signif(addend)) << (6'(eff_exp(addend)) + 6'(ADD_OFS));
      p_inf = is_inf(mul_x) | is_inf(mul_y);
      c_inf = is_inf(addend);
      bad_mul = (is_inf(mul_x) & is_zero(mul_y)) | (is_inf(mul_y) & is_zero(mul_x));

      if (ps == cs) begin
         ex.mag = p_mag + c_mag;
         ex.sgn = ps;
      end else if (p_mag > c_mag) begin
         ex.mag = p_mag - c_mag;
         ex.sgn = ps;
      end else if (c_mag > p_mag) begin
         ex.mag = c_mag - p_mag;
         ex.sgn = cs;
      end else begin
         ex.mag = '0;
         ex.sgn = 1'b0;
      end

      ex.nan = is_nan(mul_x) | is_nan(mul_y) | is_nan(addend) | bad_mul |
               (p_inf & c_inf & (ps != cs));
      ex.inf = p_inf | c_inf;
      if (p_inf)      ex.sgn = ps;
      else if (c_inf) ex.sgn = cs;
   end
endmodule

// File: rtl/pvfma_norm.sv
`timescale 1ns/1ps
module pvfma_norm
   import pvfma_pkg::*;
(
   input  logic [EXACT_W-1:0] mag,
   output logic [POS_W-1:0]   lsb
);
   logic [POS_W-1:0] lead;

   always_comb begin
      lead = '0;
      for (int i = 0; i < EXACT_W; i++)
         if (mag[i]) lead = POS_W'(i);
      // keep eleven significant bits, never finer than the subnormal step
      if (lead >= POS_W'(SUB_LSB + FRAC_W)) lsb = lead - POS_W'(FRAC_W);
      else                                  lsb = POS_W'(SUB_LSB);
   end
endmodule

// File: rtl/pvfma_round.sv
`timescale 1ns/1ps
module pvfma_round
   import pvfma_pkg::*;
(
   input  exact_t            ex,
   input  logic [POS_W-1:0]  lsb,
   output logic [HALF_W-1:0] half
);
   logic [MANT_W:0]    q;
   logic [MANT_W:0]    q_r;
   logic               guard;
   logic               sticky;
   logic [EXACT_W-1:0] low_mask;
   logic [16:0]        enc;

   always_comb begin
      q        = (MANT_W+1)'(ex.mag >> lsb);
      guard    = ex.mag[lsb - POS_W'(1)];
      low_mask = (EXACT_W'(1) << (lsb - POS_W'(1))) - EXACT_W'(1);
      sticky   = |(ex.mag & low_mask);
      q_r      = q + (MANT_W+1)'(guard & (sticky | q[0]));
      // exponent step plus significand; a carry out of q_r bumps the exponent
      enc      = (17'(lsb - POS_W'(SUB_LSB)) << FRAC_W) + 17'(q_r);

      if (ex.nan)                       half = QNAN;
      else if (ex.inf)                  half = {ex.sgn, INF_MAG};
      else if (ex.mag == '0)            half = {ex.sgn, 15'd0};
      else if (enc >= 17'(INF_MAG))     half = {ex.sgn, INF_MAG};
      else                              half = {ex.sgn, enc[14:0]};
   end
endmodule

// File: rtl/pvfma_unit.sv
`timescale 1ns/1ps
module pvfma_unit
   import pvfma_pkg::*;
#(
   parameter int VLEN = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [31:0]       insn,
   input  logic [VLEN-1:0]   src_a,
   input  logic [VLEN-1:0]   src_b,
   input  logic [VLEN-1:0]   src_acc,
   input  logic [VLEN/8-1:0] pred,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [VLEN-1:0]   result,
   output logic              dec_err,
   output logic              unsupported
);
   localparam int LANES  = VLEN / HALF_W;
   localparam int PRED_W = VLEN / 8;
   localparam int BYTES_PER_LANE = HALF_W / 8;

   if (VLEN % HALF_W != 0 || VLEN < HALF_W) begin : g_bad_vlen
      $error("VLEN must be a positive multiple of the lane width");
   end
   if (EXACT_W < 2*MANT_W + 61) begin : g_bad_exact
      $error("exact accumulator too narrow for the half-precision range");
   end

   // ---------------- stage 0: decode and lane enables ----------------
   logic             match_in;
   logic             half_in;
   logic [LANES-1:0] en_in;
   logic             any_in;
   logic             pred_odd_unused;
   logic             adv;

   pvfma_decode u_dec (.insn(insn), .match(match_in), .half_ok(half_in));

   for (genvar i = 0; i < LANES; i++) begin : g_en
      assign en_in[i] = half_in & pred[i*BYTES_PER_LANE];
   end
   assign any_in = |en_in;

   always_comb begin
      pred_odd_unused = 1'b0;
      for (int k = 0; k < PRED_W; k++)
         if (k % BYTES_PER_LANE != 0) pred_odd_unused = pred_odd_unused ^ pred[k];
   end

   assign adv      = !(out_valid && !out_ready);
   assign in_ready = adv;

   // ---------------- pipeline valid bits ----------------
   logic v1, v2, v3, v4;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1 <= 1'b0;
         v2 <= 1'b0;
         v3 <= 1'b0;
         v4 <= 1'b0;
      end else if (adv) begin
         v1 <= in_valid;
         v2 <= v1;
         v3 <= v2;
         v4 <= v3;
      end
   end

   // ---------------- stage 1: captured operands ----------------
   logic [VLEN-1:0]  a1, b1, c1;
   logic [LANES-1:0] en1;
   logic             de1, un1;

   always_ff @(posedge clk) begin
      if (adv) begin
         // with no active element the multiplicands are taken as zero
         a1  <= any_in ? src_a : '0;
         b1  <= any_in ? src_b : '0;
         c1  <= src_acc;
         en1 <= en_in;
         de1 <= !match_in;
         un1 <= match_in && !half_in;
      end
   end

   // ---------------- stage 2: exact sums ----------------
   exact_t           ex_d [LANES];
   exact_t           ex2  [LANES];
   logic [VLEN-1:0]  c2;
   logic [LANES-1:0] en2;
   logic             de2, un2;

   for (genvar i = 0; i < LANES; i++) begin : g_exact
      pvfma_exact u_exact (
         .mul_x (a1[i*HALF_W +: HALF_W]),
         .mul_y (b1[i*HALF_W +: HALF_W]),
         .addend(c1[i*HALF_W +: HALF_W]),
         .ex    (ex_d[i])
      );
   end

   always_ff @(posedge clk) begin
      if (adv) begin
         for (int i = 0; i < LANES; i++) ex2[i] <= ex_d[i];
         c2  <= c1;
         en2 <= en1;
         de2 <= de1;
         un2 <= un1;
      end
   end

   // ---------------- stage 3: rounding position ----------------
   logic [POS_W-1:0] lsb_d [LANES];
   logic [POS_W-1:0] lsb3  [LANES];
   exact_t           ex3   [LANES];
   logic [VLEN-1:0]  c3;
   logic [LANES-1:0] en3;
   logic             de3, un3;

   for (genvar i = 0; i < LANES; i++) begin : g_norm
      pvfma_norm u_norm (.mag(ex2[i].mag), .lsb(lsb_d[i]));
   end

   always_ff @(posedge clk) begin
      if (adv) begin
         for (int i = 0; i < LANES; i++) begin
            ex3[i]  <= ex2[i];
            lsb3[i] <= lsb_d[i];
         end
         c3  <= c2;
         en3 <= en2;
         de3 <= de2;
         un3 <= un2;
      end
   end

   // ---------------- stage 4: round and merge ----------------
   logic [VLEN-1:0] merged;

   for (genvar i = 0; i < LANES; i++) begin : g_round
      logic [HALF_W-1:0] rounded;
      pvfma_round u_round (.ex(ex3[i]), .lsb(lsb3[i]), .half(rounded));
      assign merged[i*HALF_W +: HALF_W] = en3[i] ? rounded : c3[i*HALF_W +: HALF_W];
   end

   always_ff @(posedge clk) begin
      if (adv) begin
         result      <= merged;
         dec_err     <= de3;
         unsupported <= un3;
      end
   end

   assign out_valid = v4;
endmodule

// File: rtl/pvfma_chk.sv
`timescale 1ns/1ps
module pvfma_chk #(
   parameter int VLEN = 128
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            in_ready,
   input logic            out_valid,
   input logic            out_ready,
   input logic [VLEN-1:0] result,
   input logic            dec_err,
   input logic            unsupported
);
   logic [1:0] up_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              up_cnt <= 2'd0;
      else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
   end

   a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(result) &&
                                  $stable(dec_err) && $stable(unsupported));

   a_r8_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (up_cnt == 2'd3) && $past(in_valid && in_ready, 3) &&
      $past(out_ready, 2) && $past(out_ready) && out_ready |=> out_valid);

   a_r8_empty_accepts: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

   a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(dec_err && unsupported));

   a_r10_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (up_cnt == 2'd0) |-> !out_valid && in_ready);
endmodule

bind pvfma_unit pvfma_chk #(.VLEN(VLEN)) u_chk (.*);

// File: tb/pvfma_unit_test.sv
`timescale 1ns/1ps
module pvfma_unit_test;
   localparam int VLEN  = 128;
   localparam int LANES = VLEN / 16;
   localparam int PW    = VLEN / 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic            in_ready;
   logic [31:0]     insn = '0;
   logic [VLEN-1:0] src_a = '0, src_b = '0, src_acc = '0;
   logic [PW-1:0]   pred = '0;
   logic            out_valid;
   logic            out_ready = 1'b1;
   logic [VLEN-1:0] result;
   logic            dec_err, unsupported;

   always #2.5 clk = ~clk;

   pvfma_unit #(.VLEN(VLEN)) uut (.*);

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit bp_on = 1'b0, done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // expected-result queue
   logic [VLEN-1:0] q_res [64];
   logic            q_de  [64];
   logic            q_un  [64];
   int              q_acc [64];
   bit              q_lat [64];
   string           q_tag [64];
   int wr = 0, rd = 0;

   function automatic logic [31:0] mk(input logic [1:0] sz, input logic [4:0] m,
                                      input logic [2:0] g, input logic [4:0] n,
                                      input logic [4:0] d);
      return {8'b0110_0101, sz, 1'b1, m, 3'b000, g, n, d};
   endfunction

   function automatic logic [15:0] ref_fma(input logic [15:0] a, input logic [15:0] b,
                                           input logic [15:0] c);
      logic [127:0] pm, cm, mag, q;
      logic ps, s, g, st;
      int ea, eb, ec, sh, enc;
      bit na, nb, nc, ia, ib, ic, za, zb;
      na = a[14:10] == 31 && a[9:0] != 0; ia = a[14:10] == 31 && a[9:0] == 0;
      nb = b[14:10] == 31 && b[9:0] != 0; ib = b[14:10] == 31 && b[9:0] == 0;
      nc = c[14:10] == 31 && c[9:0] != 0; ic = c[14:10] == 31 && c[9:0] == 0;
      za = a[14:0] == 0; zb = b[14:0] == 0;
      ps = a[15] ^ b[15];
      if (na || nb || nc) return 16'h7E00;
      if ((ia && zb) || (ib && za)) return 16'h7E00;
      if (ia || ib) begin
         if (ic && c[15] != ps) return 16'h7E00;
         return {ps, 15'h7C00};
      end
      if (ic) return c;
      ea = (a[14:10] == 0) ? 1 : int'(a[14:10]);
      eb = (b[14:10] == 0) ? 1 : int'(b[14:10]);
      ec = (c[14:10] == 0) ? 1 : int'(c[14:10]);
      pm = (128'({a[14:10] != 0, a[9:0]}) * 128'({b[14:10] != 0, b[9:0]})) << (ea + eb);
      cm = 128'({c[14:10] != 0, c[9:0]}) << (ec + 25);
      if (ps == c[15]) begin mag = pm + cm; s = ps; end
      else if (pm >= cm) begin mag = pm - cm; s = ps; end
      else begin mag = cm - pm; s = c[15]; end
      if (mag == 0) return {ps & c[15], 15'd0};
      q = mag; sh = 0; g = 0; st = 0;
      while (q >= 2048 || sh < 26) begin
         st = st | g; g = q[0]; q = q >> 1; sh++;
      end
      if (g && (st || q[0])) q = q + 1;
      enc = (sh - 26) * 1024 + int'(q);
      if (enc >= 32'h7C00) return {s, 15'h7C00};
      return {s, 15'(enc)};
   endfunction

   task automatic ref_vec(input logic [31:0] w, input logic [VLEN-1:0] a, b, c,
                          input logic [PW-1:0] p, output logic [VLEN-1:0] r,
                          output logic de, output logic un);
      bit ok;
      ok = w[31:24] == 8'h65 && w[21] && w[15:13] == 0 && w[23:22] != 0;
      de = !ok; un = ok && w[23:22] != 2'b01; r = c;
      if (ok && !un)
         for (int i = 0; i < LANES; i++)
            if (p[2*i]) r[16*i +: 16] = ref_fma(a[16*i +: 16], b[16*i +: 16], c[16*i +: 16]);
   endtask

   task automatic send(input logic [31:0] w, input logic [VLEN-1:0] a, b, c,
                       input logic [PW-1:0] p, input string tag, input bit lat);
      logic [VLEN-1:0] r; logic de, un;
      ref_vec(w, a, b, c, p, r, de, un);
      @(posedge clk); #1;
      insn = w; src_a = a; src_b = b; src_acc = c; pred = p; in_valid = 1'b1;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
      in_valid = 1'b0;
      q_res[wr % 64] = r; q_de[wr % 64] = de; q_un[wr % 64] = un;
      q_acc[wr % 64] = cyc; q_lat[wr % 64] = lat; q_tag[wr % 64] = tag;
      wr++;
   endtask

   // output monitor, sampled mid-cycle
   logic [VLEN-1:0] hold_res;
   bit hold_pend = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (hold_pend) begin
            n_chk++;
            if (!out_valid || result !== hold_res) begin
               n_bad++;
               $display("FAIL R9 stall hold: valid=%0b result=%h expected %h", out_valid, result, hold_res);
            end
         end
         hold_pend = out_valid && !out_ready;
         hold_res  = result;
         if (out_valid && out_ready) begin
            n_chk++;
            if (rd == wr) begin
               n_bad++;
               $display("FAIL R8 unexpected output: valid=1 expected no output");
            end else begin
               if (result !== q_res[rd % 64] || dec_err !== q_de[rd % 64] || unsupported !== q_un[rd % 64]) begin
                  n_bad++;
                  $display("FAIL %s: result=%h de=%0b un=%0b expected %h de=%0b un=%0b",
                           q_tag[rd % 64], result, dec_err, unsupported,
                           q_res[rd % 64], q_de[rd % 64], q_un[rd % 64]);
               end
               if (q_lat[rd % 64]) begin
                  n_chk++;
                  if (cyc - q_acc[rd % 64] != 3) begin
                     n_bad++;
                     $display("FAIL R8 latency: %0d expected 3", cyc - q_acc[rd % 64]);
                  end
               end
               rd++;
            end
         end
      end
   end

   initial begin
      forever begin
         @(posedge clk); #1;
         out_ready = bp_on ? ($urandom % 3 != 0) : 1'b1;
      end
   end

   function automatic logic [15:0] rnd_h();
      logic [15:0] pool [10] = '{16'h0000, 16'h8000, 16'h7C00, 16'hFC00, 16'h7E00,
                                 16'h0001, 16'h03FF, 16'h0400, 16'h7BFF, 16'h3C00};
      case ($urandom % 4)
         0: return 16'($urandom);
         1: return {1'($urandom), 5'(13 + $urandom % 5), 10'($urandom)};
         2: return pool[$urandom % 10];
         default: return {1'($urandom), 5'(1 + $urandom % 30), 10'($urandom)};
      endcase
   endfunction

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R8 watchdog: run hung, expected completion");
         finish_run();
      end
   end

   initial begin
      logic [VLEN-1:0] a, b, c;
      logic [31:0] w;
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
         n_bad++;
         $display("FAIL R10 reset: valid=%0b ready=%0b expected 0 1", out_valid, in_ready);
      end
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
         n_bad++;
         $display("FAIL R10 after reset: valid=%0b ready=%0b expected 0 1", out_valid, in_ready);
      end

      // directed corner lanes
      a = {16'h3C01, 16'h0001, 16'h7BFF, 16'h3C00, 16'h8000, 16'h7C00, 16'h7C00, 16'h3C00};
      b = {16'h3C01, 16'h3800, 16'h4000, 16'h3C00, 16'h3C00, 16'h3C00, 16'h0000, 16'h3C00};
      c = {16'hBC02, 16'h0000, 16'h0000, 16'hBC00, 16'h8000, 16'hFC00, 16'h3C00, 16'h3C00};
      send(mk(2'b01, 5'd1, 3'd2, 5'd3, 5'd4), a, b, c, 16'hFFFF, "R4 R6 R7 corners", 1'b1);
      a[15:0] = 16'h7E00; b[31:16] = 16'h8000; c[31:16] = 16'h0000;
      a[127:112] = 16'h0001; b[127:112] = 16'h3E00; c[127:112] = 16'h0000;
      send(mk(2'b01, 5'd7, 3'd1, 5'd9, 5'd2), a, b, c, 16'h5555, "R4 R6 R7 nan tie zero", 1'b1);
      send(mk(2'b01, 5'd0, 3'd0, 5'd0, 5'd0), a, b, c, 16'h0000, "R5 no active lane", 1'b1);
      send(mk(2'b01, 5'd3, 3'd3, 5'd3, 5'd3), a, b, c, 16'hAAAA, "R3 odd predicate bits", 1'b1);
      send(mk(2'b01, 5'd3, 3'd3, 5'd3, 5'd3), a, b, c, 16'h0005, "R3 R5 sparse lanes", 1'b1);
      send(mk(2'b10, 5'd1, 3'd1, 5'd1, 5'd1), a, b, c, 16'hFFFF, "R2 size 32", 1'b1);
      send(mk(2'b11, 5'd1, 3'd1, 5'd1, 5'd1), a, b, c, 16'hFFFF, "R2 size 64", 1'b1);
      send(mk(2'b00, 5'd1, 3'd1, 5'd1, 5'd1), a, b, c, 16'hFFFF, "R1 size 00", 1'b1);
      w = mk(2'b01, 5'd1, 3'd1, 5'd1, 5'd1); w[21] = 1'b0;
      send(w, a, b, c, 16'hFFFF, "R1 bit21 clear", 1'b1);
      w = mk(2'b01, 5'd1, 3'd1, 5'd1, 5'd1); w[13] = 1'b1;
      send(w, a, b, c, 16'hFFFF, "R1 opcode bits", 1'b1);
      while (rd != wr) @(negedge clk);

      // random phase under backpressure
      bp_on = 1'b1;
      for (int t = 0; t < 400; t++) begin
         for (int i = 0; i < LANES; i++) begin
            a[16*i +: 16] = rnd_h(); b[16*i +: 16] = rnd_h(); c[16*i +: 16] = rnd_h();
         end
         case ($urandom % 10)
            7:       w = mk(2'($urandom % 2 + 2), 5'($urandom), 3'($urandom), 5'($urandom), 5'($urandom));
            8, 9:    w = $urandom;
            default: w = mk(2'b01, 5'($urandom), 3'($urandom), 5'($urandom), 5'($urandom));
         endcase
         send(w, a, b, c, 16'($urandom), "R1 R2 R3 R4 R5 R9 random", 1'b0);
      end
      while (rd != wr) @(negedge clk);
      bp_on = 1'b0;
      repeat (4) @(posedge clk);
      done = 1'b1;
      finish_run();
   end
endmodule